// File: doc/BRIEF.md
# Small-Format Floating-Point Add/Subtract Datapath

This block adds or subtracts two numbers held in a small floating-point format. Each number has one sign bit, an exponent field stored with a bias, and a fraction whose leading one is implied. The block aligns the two operands, forms the sum or difference of their magnitudes and normalizes the result. It does not round. Instead it delivers the unrounded mantissa, including its leading bit, together with three extra low-order bits. A separate rounding stage downstream can then apply any rounding mode exactly.

Operands whose exponent field is all zeros are denormal. For these the implied bit is zero and they are treated as having the smallest normal exponent. Results that become too small to normalize are also delivered as denormals. NaN and infinity inputs are resolved by fixed rules and reported through a class code. The result is registered: one valid operation in produces one result one clock later.

Top module: `mini_float_adder`

## Requirements
- R1: `out_valid` is 0 out of reset, with all result outputs zero. A cycle with `in_valid` high produces `out_valid` high on the next rising edge. A cycle with `in_valid` low produces `out_valid` low on the next edge.
- R2: The operand with the smaller magnitude has its mantissa shifted right by the exponent difference. The two bits just below the mantissa LSB are kept as guard and round, `res_grs[2]` and `res_grs[1]`. `res_mant` is MAN_W+1 bits wide with the leading bit at the MSB.
- R3: `res_grs[0]` (sticky) is 1 when any 1 bit is shifted below the round position during alignment. When the shift exceeds MAN_W+3, the whole smaller mantissa folds into sticky.
- R4: A difference that is exactly representable comes out exact, with guard, round and sticky all zero.
- R5: A carry out of the magnitude add shifts the result right by one and adds one to the exponent. The two lowest bits are ORed into sticky.
- R6: A result with leading zeros shifts left until its leading bit is 1, or until the exponent reaches 1. If the leading bit is still 0 at that point, the exponent field output is 0 (denormal).
- R7: An input exponent field of 0 means an implied bit of 0 and an effective exponent of 1. Two denormals can therefore sum into a normal number with exponent field 1.
- R8: `sub_en` inverts the sign of `op_b`. The result takes the sign of the operand with the larger magnitude.
- R9: An exact zero from operands of opposite effective sign is +0. Adding two zeros of the same sign keeps that sign.
- R10: If either input is a NaN, the result has `res_cls`=2, sign 0, exponent all ones, and a mantissa with only bit MAN_W-1 set. The same NaN result is produced for infinities of opposite effective sign.
- R11: An infinity input, or a carry into the all-ones exponent, gives `res_cls`=1 with the exponent all ones and the mantissa and grs zero. The sign is the infinity's own sign, or the result's sign on overflow. Ordinary finite results have `res_cls`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands valid this cycle |
| op_a | input | 1+EXP_W+MAN_W | First operand {sign, exponent, fraction} |
| op_b | input | 1+EXP_W+MAN_W | Second operand {sign, exponent, fraction} |
| sub_en | input | 1 | 1 computes op_a - op_b, 0 computes op_a + op_b |
| out_valid | output | 1 | Result valid |
| res_sign | output | 1 | Result sign |
| res_exp | output | EXP_W | Result exponent field (0 for denormal or zero) |
| res_mant | output | MAN_W+1 | Unrounded mantissa with leading bit at MSB |
| res_grs | output | 3 | {guard, round, sticky} |
| res_cls | output | 2 | 0 finite, 1 infinity, 2 NaN |

## Verification
The bench targets the following corner cases:
- **Near-cancelling subtraction.** The bench uses two close operands. A datapath without a guard bit would return twice the exact value.
- **Far alignment.** The bench shifts the smaller mantissa so far that it drops entirely into sticky. A design that let it vanish would report an exact result that is not exact.
- **Underflow to denormal.** The bench subtracts two tiny values. A left shift that ignores the exponent floor would produce a wrapped exponent.
- **Carry into the top exponent.** A design that missed it would emit an all-ones exponent marked finite.
- **Signed zeros, NaN and infinity.** These cases catch sign selection that follows the wrong operand and infinity arithmetic that returns infinity instead of NaN.

// File: rtl/mfa_pkg.sv
package mfa_pkg;
  typedef enum logic [1:0] {
    CLS_NUM = 2'd0,
    CLS_INF = 2'd1,
    CLS_NAN = 2'd2
  } mfa_cls_e;
endpackage

// File: rtl/mfa_unpack.sv
module mfa_unpack #(
  parameter int EXP_W = 4,
  parameter int MAN_W = 3,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0]     op,
  output logic             sign,
  output logic [EXP_W-1:0] eff_exp,
  output logic [MAN_W:0]   mant,
  output logic             is_nan,
  output logic             is_inf
);
  logic [EXP_W-1:0] fld;
  logic [MAN_W-1:0] frac;

  assign fld     = op[W-2:MAN_W];
  assign frac    = op[MAN_W-1:0];
  assign sign    = op[W-1];
  assign eff_exp = (fld == '0) ? EXP_W'(1) : fld;
  assign mant    = {(fld != '0), frac};
  assign is_nan  = (&fld) & (|frac);
  assign is_inf  = (&fld) & ~(|frac);
endmodule

// File: rtl/mfa_align.sv
module mfa_align #(
  parameter int EXP_W = 4,
  parameter int MAN_W = 3,
  localparam int K    = MAN_W + 1,
  localparam int DW   = K + 3,
  localparam int WIDE = 2 * K + 4
) (
  input  logic             a_sign,
  input  logic [EXP_W-1:0] a_exp,
  input  logic [K-1:0]     a_mant,
  input  logic             b_sign,
  input  logic [EXP_W-1:0] b_exp,
  input  logic [K-1:0]     b_mant,
  output logic             big_sign,
  output logic             eff_sub,
  output logic [EXP_W-1:0] big_exp,
  output logic [DW-1:0]    big_ext,
  output logic [DW-1:0]    small_ext
);
  logic             a_ge;
  logic [EXP_W-1:0] diff;
  logic [K-1:0]     s_mant;
  logic [WIDE-1:0]  wide;

  always_comb begin
    a_ge     = {a_exp, a_mant} >= {b_exp, b_mant};
    big_sign = a_ge ? a_sign : b_sign;
    big_exp  = a_ge ? a_exp : b_exp;
    diff     = a_ge ? (a_exp - b_exp) : (b_exp - a_exp);
    s_mant   = a_ge ? b_mant : a_mant;
    big_ext  = {(a_ge ? a_mant : b_mant), 3'b000};
    eff_sub  = a_sign ^ b_sign;
    wide     = {s_mant, {(K + 4){1'b0}}} >> diff;
    if (int'(diff) > K + 2)
      small_ext = {{(DW - 1){1'b0}}, |s_mant};
    else
      small_ext = {wide[WIDE-1 -: K+2], |wide[K+1:0]};
  end
endmodule

// File: rtl/mfa_addnorm.sv
module mfa_addnorm #(
  parameter int EXP_W = 4,
  parameter int MAN_W = 3,
  localparam int K  = MAN_W + 1,
  localparam int DW = K + 3
) (
  input  logic             big_sign,
  input  logic             eff_sub,
  input  logic [EXP_W-1:0] big_exp,
  input  logic [DW-1:0]    big_ext,
  input  logic [DW-1:0]    small_ext,
  output logic             res_sign,
  output logic [EXP_W-1:0] res_exp,
  output logic [K-1:0]     res_mant,
  output logic [2:0]       res_grs,
  output logic             ovf
);
  logic [DW:0]   sum;
  logic [DW-1:0] vec;
  logic          found;
  int            lz;
  int            sh;
  int            room;

  always_comb begin
    sum = eff_sub ? ({1'b0, big_ext} - {1'b0, small_ext})
                  : ({1'b0, big_ext} + {1'b0, small_ext});
    lz    = 0;
    found = 1'b0;
    for (int i = DW - 1; i >= 0; i--) begin
      if (!found) begin
        if (sum[i]) found = 1'b1;
        else        lz    = lz + 1;
      end
    end
    room     = int'(big_exp) - 1;
    sh       = (lz > room) ? room : lz;
    ovf      = 1'b0;
    res_sign = big_sign;
    res_exp  = big_exp;
    vec      = '0;
    if (sum[DW]) begin
      vec     = {sum[DW:2], sum[1] | sum[0]};
      res_exp = big_exp + 1'b1;
      ovf     = (res_exp == '1);
    end else if (sum[DW-1:0] == '0) begin
      res_sign = eff_sub ? 1'b0 : big_sign;
      res_exp  = '0;
    end else begin
      vec     = sum[DW-1:0] << sh;
      vec[0]  = vec[0] | sum[0];
      res_exp = vec[DW-1] ? (big_exp - EXP_W'(sh)) : '0;
    end
  end

  assign res_mant = vec[DW-1:DW-K];
  assign res_grs  = vec[2:0];
endmodule

// File: rtl/mini_float_adder.sv
module mini_float_adder
  import mfa_pkg::*;
#(
  parameter int EXP_W = 4,
  parameter int MAN_W = 3,
  localparam int W  = 1 + EXP_W + MAN_W,
  localparam int K  = MAN_W + 1,
  localparam int DW = K + 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [W-1:0]     op_a,
  input  logic [W-1:0]     op_b,
  input  logic             sub_en,
  output logic             out_valid,
  output logic             res_sign,
  output logic [EXP_W-1:0] res_exp,
  output logic [K-1:0]     res_mant,
  output logic [2:0]       res_grs,
  output logic [1:0]       res_cls
);
  logic [W-1:0]     ops    [2];
  logic             u_sign [2];
  logic [EXP_W-1:0] u_exp  [2];
  logic [K-1:0]     u_mant [2];
  logic             u_nan  [2];
  logic             u_inf  [2];

  assign ops[0] = op_a;
  assign ops[1] = {op_b[W-1] ^ sub_en, op_b[W-2:0]};

  for (genvar g = 0; g < 2; g++) begin : g_unp
    mfa_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_unpack (
      .op(ops[g]), .sign(u_sign[g]), .eff_exp(u_exp[g]),
      .mant(u_mant[g]), .is_nan(u_nan[g]), .is_inf(u_inf[g])
    );
  end

  logic             big_sign, eff_sub, ovf;
  logic [EXP_W-1:0] big_exp;
  logic [DW-1:0]    big_ext, small_ext;
  logic             n_sign;
  logic [EXP_W-1:0] n_exp;
  logic [K-1:0]     n_mant;
  logic [2:0]       n_grs;

  mfa_align #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_align (
    .a_sign(u_sign[0]), .a_exp(u_exp[0]), .a_mant(u_mant[0]),
    .b_sign(u_sign[1]), .b_exp(u_exp[1]), .b_mant(u_mant[1]),
    .big_sign(big_sign), .eff_sub(eff_sub), .big_exp(big_exp),
    .big_ext(big_ext), .small_ext(small_ext)
  );

  mfa_addnorm #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_addnorm (
    .big_sign(big_sign), .eff_sub(eff_sub), .big_exp(big_exp),
    .big_ext(big_ext), .small_ext(small_ext),
    .res_sign(n_sign), .res_exp(n_exp), .res_mant(n_mant),
    .res_grs(n_grs), .ovf(ovf)
  );

  // special-value resolution
  logic             d_sign;
  logic [EXP_W-1:0] d_exp;
  logic [K-1:0]     d_mant;
  logic [2:0]       d_grs;
  mfa_cls_e         d_cls;

  always_comb begin
    d_sign = n_sign;
    d_exp  = n_exp;
    d_mant = n_mant;
    d_grs  = n_grs;
    d_cls  = CLS_NUM;
    if (u_nan[0] || u_nan[1] ||
        (u_inf[0] && u_inf[1] && (u_sign[0] != u_sign[1]))) begin
      d_cls  = CLS_NAN;
      d_sign = 1'b0;
      d_exp  = '1;
      d_mant = K'(1) << (MAN_W - 1);
      d_grs  = '0;
    end else if (u_inf[0] || u_inf[1] || ovf) begin
      d_cls  = CLS_INF;
      d_sign = u_inf[0] ? u_sign[0] : (u_inf[1] ? u_sign[1] : n_sign);
      d_exp  = '1;
      d_mant = '0;
      d_grs  = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      res_sign  <= 1'b0;
      res_exp   <= '0;
      res_mant  <= '0;
      res_grs   <= '0;
      res_cls   <= CLS_NUM;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        res_sign <= d_sign;
        res_exp  <= d_exp;
        res_mant <= d_mant;
        res_grs  <= d_grs;
        res_cls  <= d_cls;
      end
    end
  end
endmodule

// File: rtl/mfa_checker.sv
module mfa_checker #(
  parameter int EXP_W = 4,
  parameter int MAN_W = 3,
  localparam int W = 1 + EXP_W + MAN_W,
  localparam int K = MAN_W + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [W-1:0]     op_a,
  input logic [W-1:0]     op_b,
  input logic             sub_en,
  input logic             out_valid,
  input logic             res_sign,
  input logic [EXP_W-1:0] res_exp,
  input logic [K-1:0]     res_mant,
  input logic [1:0]       res_cls
);
  logic a_nan, b_nan, a_spec, cancel;
  assign a_nan  = (&op_a[W-2:MAN_W]) & (|op_a[MAN_W-1:0]);
  assign b_nan  = (&op_b[W-2:MAN_W]) & (|op_b[MAN_W-1:0]);
  assign a_spec = &op_a[W-2:MAN_W];
  assign cancel = (op_a[W-2:0] == op_b[W-2:0]) & (op_a[W-1] ^ op_b[W-1] ^ sub_en ^ 1'b1) == 1'b0;

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R1
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R1
  AST_NORMAL_LEAD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && res_cls == 2'd0 && res_exp != '0) |-> res_mant[K-1]); // R6
  AST_DENORM_LEAD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && res_cls == 2'd0 && res_exp == '0) |-> !res_mant[K-1]); // R6
  AST_NAN_IN: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (a_nan || b_nan)) |=> (res_cls == 2'd2)); // R10
  AST_INF_SHAPE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && res_cls == 2'd1) |-> (res_exp == '1 && res_mant == '0)); // R11
  AST_CANCEL_POS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cancel && !a_spec) |=> (!res_sign && res_exp == '0 && res_mant == '0)); // R9
endmodule

bind mini_float_adder mfa_checker #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_mfa_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
  .sub_en(sub_en), .out_valid(out_valid), .res_sign(res_sign),
  .res_exp(res_exp), .res_mant(res_mant), .res_cls(res_cls)
);

// File: tb/tb_mini_float_adder.sv
`timescale 1ns/1ps
module tb_mini_float_adder;
  localparam int EXP_W = 4;
  localparam int MAN_W = 3;
  localparam int NV    = 17;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] op_a = '0, op_b = '0;
  logic       sub_en = 1'b0;
  logic       out_valid, res_sign;
  logic [3:0] res_exp, res_mant;
  logic [2:0] res_grs;
  logic [1:0] res_cls;
  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  mini_float_adder #(.EXP_W(EXP_W), .MAN_W(MAN_W)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .sub_en(sub_en), .out_valid(out_valid), .res_sign(res_sign),
    .res_exp(res_exp), .res_mant(res_mant), .res_grs(res_grs), .res_cls(res_cls)
  );

  // {a, b, sub, exp sign, exp exponent, exp mant, exp grs, exp class}
  localparam logic [30:0] VEC [NV] = '{
    {8'h38, 8'h38, 1'b0, 1'b0, 4'h8, 4'h8, 3'd0, 2'd0}, // R5 carry: 1+1
    {8'h40, 8'h3E, 1'b1, 1'b0, 4'h5, 4'h8, 3'd0, 2'd0}, // R4 exact 2-1.75
    {8'h38, 8'h19, 1'b0, 1'b0, 4'h7, 4'h8, 3'd5, 2'd0}, // R3 sticky
    {8'h40, 8'h05, 1'b1, 1'b0, 4'h7, 4'hF, 3'd7, 2'd0}, // R3 collapse
    {8'h38, 8'h38, 1'b1, 1'b0, 4'h0, 4'h0, 3'd0, 2'd0}, // R9 x-x
    {8'hB8, 8'h38, 1'b0, 1'b0, 4'h0, 4'h0, 3'd0, 2'd0}, // R9 -1+1
    {8'h80, 8'h80, 1'b0, 1'b1, 4'h0, 4'h0, 3'd0, 2'd0}, // R9 -0+-0
    {8'h08, 8'h04, 1'b1, 1'b0, 4'h0, 4'h4, 3'd0, 2'd0}, // R6 denormal result
    {8'h04, 8'h04, 1'b0, 1'b0, 4'h1, 4'h8, 3'd0, 2'd0}, // R7 denormals sum
    {8'h38, 8'h40, 1'b1, 1'b1, 4'h7, 4'h8, 3'd0, 2'd0}, // R8 1-2
    {8'h7C, 8'h38, 1'b0, 1'b0, 4'hF, 4'h4, 3'd0, 2'd2}, // R10 NaN in
    {8'h78, 8'h78, 1'b1, 1'b0, 4'hF, 4'h4, 3'd0, 2'd2}, // R10 inf-inf
    {8'h78, 8'h78, 1'b0, 1'b0, 4'hF, 4'h0, 3'd0, 2'd1}, // R11 inf+inf
    {8'h38, 8'hF8, 1'b0, 1'b1, 4'hF, 4'h0, 3'd0, 2'd1}, // R11 1+-inf
    {8'h77, 8'h77, 1'b0, 1'b0, 4'hF, 4'h0, 3'd0, 2'd1}, // R11 overflow
    {8'h38, 8'h30, 1'b0, 1'b0, 4'h7, 4'hC, 3'd0, 2'd0}, // R2 1+0.5
    {8'h38, 8'h29, 1'b0, 1'b0, 4'h7, 4'hA, 3'd2, 2'd0}  // R2 guard/round
  };

  task automatic check(input string tag, input logic [13:0] act, input logic [13:0] exp_v);
    n_tests++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp_v);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset", {out_valid, res_sign, res_exp, res_mant, res_grs, res_cls}, '0);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {op_a, op_b, sub_en} = VEC[i][30:14];
      in_valid = 1'b1;
      @(posedge clk);
      #1;
      check($sformatf("R1/vec%0d valid", i), {13'd0, out_valid}, 14'd1);
      check($sformatf("vec%0d result", i),
            {res_sign, res_exp, res_mant, res_grs, res_cls}, VEC[i][13:0]);
    end
    // R1: idle cycle drops out_valid
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk);
    #1;
    check("R1 idle", {13'd0, out_valid}, 14'd0);
    // R8: sub_en flips op_b sign: 1 - (-1) = 2
    @(negedge clk);
    op_a = 8'h38; op_b = 8'hB8; sub_en = 1'b1; in_valid = 1'b1;
    @(posedge clk);
    #1;
    check("R8 sub of negative", {res_sign, res_exp, res_mant, res_grs, res_cls},
          {1'b0, 4'h8, 4'h8, 3'd0, 2'd0});
    // R1: reset mid-stream clears outputs
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check("R1 reset again", {out_valid, res_sign, res_exp, res_mant, res_grs, res_cls}, '0);
    @(negedge clk);
    rst = 1'b0;
    in_valid = 1'b0;
    @(posedge clk);
    finish_run();
  end
endmodule